// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block picks which page frame to give up when a new page must be brought in. The frames form a ring. A hand pointer marks the oldest frame, and each frame carries one referenced bit. When a replacement is requested, the block walks the ring from the hand, one frame per clock. A frame whose referenced bit is set loses that bit and is passed over, so it gets one more round before it can be evicted. The first frame found with its bit clear is returned as the victim.

Page accesses report themselves through a reference strobe with a frame index, which sets that frame's bit. After a victim is returned, the hand moves past it and its bit is set, because the frame now holds a freshly loaded page. Loading the page itself is left to the surrounding logic.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every referenced bit is clear, the hand points at frame 0, `req_ready` is 1 and `victim_valid` is 0, so the first request returns frame 0 one cycle after it is accepted.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until the victim is reported.
- R3: While searching, the block examines the frame under the hand once per cycle. If that frame's bit is 1, the bit is cleared and the hand moves to the next frame.
- R4: If the examined frame's bit is 0, that frame becomes the victim. `victim_valid` is high for exactly one cycle with `victim_frame` equal to its index, and `req_ready` returns to 1 in the same cycle.
- R5: When a victim is chosen, its referenced bit is set and the hand moves to the following frame, so the next search starts just after it.
- R6: A cycle with `ref_strobe` high sets the referenced bit of frame `ref_frame`, whether or not a search is running.
- R7: If a reference and a search clear hit the same frame in the same cycle, the reference wins and the bit stays 1.
- R8: If no reference arrives during a search and all bits are set, the search clears every bit and returns the frame it started on. The victim is visible NUM_FRAMES+1 cycles after acceptance (9 cycles with 8 frames).
- R9: The hand steps through frames in ascending order and wraps from frame NUM_FRAMES-1 (7) to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Replacement request |
| req_ready | output | 1 | High when idle and able to take a request |
| ref_strobe | input | 1 | A page in a frame was accessed |
| ref_frame | input | 3 | Index of the accessed frame |
| victim_valid | output | 1 | One-cycle pulse: victim index is valid |
| victim_frame | output | 3 | Index of the frame chosen for eviction |

## Verification
The hardest case to reach is a reference that lands on the same frame, in the same cycle, as the search clears that frame's bit. From the ports this shows up only as a different victim many requests later. The stimulus first builds a known bit pattern with references and requests. It then drives the reference strobe in the exact cycle after acceptance, which is the cycle the search examines the hand's frame. Further requests walk the hand back round to that frame, and the bench checks both which frame is chosen and the search length. A full-ring search, where every bit is set and the hand wraps, is reached by referencing all frames before a request. A random phase is compared cycle by cycle against a behavioural model.

// File: rtl/clkvs_pkg.sv
package clkvs_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;

  // next position on a ring of n slots
  function automatic int ring_next(input int pos, input int n);
    return (pos + 1 >= n) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/refbit_ring.sv
module refbit_ring #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic [IW-1:0] ref_idx,
  input  logic          pick_en,
  input  logic [IW-1:0] pick_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  bits_o
);

  logic [N-1:0] bits_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = (ref_en  && (int'(ref_idx)  == g)) ||
                     (pick_en && (int'(pick_idx) == g));
    assign hit_clr = clr_en && (int'(clr_idx) == g);

    always_ff @(posedge clk) begin
      if (!rst_n)       bits_q[g] <= 1'b0;
      else if (hit_set) bits_q[g] <= 1'b1;   // set dominates clear
      else if (hit_clr) bits_q[g] <= 1'b0;
    end
  end

  assign bits_o = bits_q;

  // a reference always leaves its frame marked
  assert_ref_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en |=> bits_o[$past(ref_idx)]);

  // collision of reference and clear keeps the bit
  assert_ref_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en && clr_en && ref_idx == clr_idx) |=> bits_o[$past(clr_idx)]);

endmodule

// File: rtl/hand_ring.sv
module hand_ring
  import clkvs_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] hand_o
);

  logic [IW-1:0] hand_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   hand_q <= '0;
    else if (adv) hand_q <= IW'(ring_next(int'(hand_q), N));
  end

  assign hand_o = hand_q;

  // hand only moves on a step
  assert_hand_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hand_o));

  assert_hand_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hand_o) < N);

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import clkvs_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          cur_bit_i,
  input  logic [IW-1:0] hand_i,
  output logic          skip_o,
  output logic          pick_o,
  output logic          vic_valid_o,
  output logic [IW-1:0] vic_idx_o
);

  scan_st_e      st_q;
  logic          vic_valid_q;
  logic [IW-1:0] vic_idx_q;
  logic          accept;

  assign ready_o = (st_q == ST_IDLE);
  assign accept  = ready_o && req_i;
  assign skip_o  = (st_q == ST_SCAN) &&  cur_bit_i;
  assign pick_o  = (st_q == ST_SCAN) && !cur_bit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      vic_valid_q <= 1'b0;
      vic_idx_q   <= '0;
    end else begin
      vic_valid_q <= pick_o;
      if (pick_o) begin
        vic_idx_q <= hand_i;
        st_q      <= ST_IDLE;
      end else if (accept) begin
        st_q      <= ST_SCAN;
      end
    end
  end

  assign vic_valid_o = vic_valid_q;
  assign vic_idx_o   = vic_idx_q;

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready_o);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid_o |=> !vic_valid_o);

  assert_ready_with_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid_o |-> ready_o);

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  localparam int IW = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          ref_strobe,
  input  logic [IW-1:0] ref_frame,
  output logic          victim_valid,
  output logic [IW-1:0] victim_frame
);

  localparam int CW = IW + 2;

  logic [NUM_FRAMES-1:0] ref_bits;
  logic [IW-1:0]         hand;
  logic                  evt_skip, evt_pick, evt_accept;
  logic                  cur_bit;

  assign cur_bit    = ref_bits[hand];
  assign evt_accept = req_valid && req_ready;

  refbit_ring #(.N(NUM_FRAMES), .IW(IW)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_en  (ref_strobe),
    .ref_idx (ref_frame),
    .pick_en (evt_pick),
    .pick_idx(hand),
    .clr_en  (evt_skip),
    .clr_idx (hand),
    .bits_o  (ref_bits)
  );

  hand_ring #(.N(NUM_FRAMES), .IW(IW)) u_hand (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (evt_skip || evt_pick),
    .hand_o(hand)
  );

  scan_fsm #(.N(NUM_FRAMES), .IW(IW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_valid),
    .ready_o    (req_ready),
    .cur_bit_i  (cur_bit),
    .hand_i     (hand),
    .skip_o     (evt_skip),
    .pick_o     (evt_pick),
    .vic_valid_o(victim_valid),
    .vic_idx_o  (victim_frame)
  );

  // search-length watch: skips since acceptance, and whether a reference disturbed it
  logic [CW-1:0] skip_cnt;
  logic          ref_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_cnt <= '0;
      ref_seen <= 1'b0;
    end else if (evt_accept) begin
      skip_cnt <= '0;
      ref_seen <= 1'b0;
    end else begin
      if (evt_skip)   skip_cnt <= skip_cnt + 1'b1;
      if (ref_strobe) ref_seen <= 1'b1;
    end
  end

  assert_skip_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_skip && !(ref_strobe && ref_frame == hand)) |=> !ref_bits[$past(hand)]);

  assert_step_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_skip || evt_pick) |=> (hand != $past(hand)));

  assert_victim_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pick |=> ref_bits[$past(hand)]);

  assert_victim_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pick |=> (victim_valid && victim_frame == $past(hand)));

  assert_search_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pick && !ref_seen) |-> (int'(skip_cnt) <= NUM_FRAMES));

endmodule

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;

  localparam int NF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       ref_strobe = 1'b0;
  logic [2:0] ref_frame = '0;
  logic       req_ready, victim_valid;
  logic [2:0] victim_frame;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 8 ns period

  clock_victim_sel u_clock_victim_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .ref_strobe  (ref_strobe),
    .ref_frame   (ref_frame),
    .victim_valid(victim_valid),
    .victim_frame(victim_frame)
  );

  // behavioural reference: a ring of marks with a pointer
  bit m_mark[NF];
  int m_ptr = 0;
  bit m_busy = 0;
  bit m_vv = 0;
  int m_vi = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mark[i]) m_mark[i] = 0;
      m_ptr = 0; m_busy = 0; m_vv = 0; m_vi = 0;
    end else begin
      bit fresh;
      fresh = 0;
      if (m_busy) begin
        if (m_mark[m_ptr]) begin
          m_mark[m_ptr] = 0;
        end else begin
          m_vi = m_ptr; fresh = 1; m_busy = 0;
          m_mark[m_ptr] = 1;
        end
        m_ptr = (m_ptr == NF - 1) ? 0 : m_ptr + 1;
      end else if (req_valid) begin
        m_busy = 1;
      end
      if (ref_strobe) m_mark[ref_frame] = 1;
      m_vv = fresh;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compared every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == !m_busy, "R2 ready vs model", int'(req_ready), int'(!m_busy));
      check(victim_valid == m_vv, "R4 victim_valid vs model", int'(victim_valid), int'(m_vv));
      if (m_vv)
        check(int'(victim_frame) == m_vi, "R4 victim_frame vs model", int'(victim_frame), m_vi);
    end
  end

  // request one victim; optional reference in the first search cycle
  task automatic run_req(input bit do_ref, input int ridx, output int idx, output int cyc);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (do_ref) begin
      ref_strobe = 1'b1;
      ref_frame  = 3'(ridx);
    end
    cyc = 0;
    idx = -1;
    while (cyc < 40) begin
      @(negedge clk);
      ref_strobe = 1'b0;
      cyc++;
      if (victim_valid) begin
        idx = int'(victim_frame);
        break;
      end
      check(!req_ready, "R2 ready low while searching", int'(req_ready), 0);
    end
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    ref_strobe = 1'b1;
    ref_frame  = 3'(f);
    @(negedge clk);
    ref_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx, cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(victim_valid == 1'b0, "R1 no victim after reset", int'(victim_valid), 0);

    run_req(0, 0, idx, cyc);
    check(idx == 0, "R1 first victim", idx, 0);
    check(cyc == 1, "R4 first victim latency", cyc, 1);
    @(negedge clk);
    check(!victim_valid, "R4 pulse one cycle", int'(victim_valid), 0);

    run_req(0, 0, idx, cyc);
    check(idx == 1, "R5 hand past victim", idx, 1);

    // every frame referenced: full revolution from frame 2 with wrap
    for (int f = 0; f < NF; f++) touch(f);
    run_req(0, 0, idx, cyc);
    check(idx == 2, "R8 full ring returns start frame", idx, 2);
    check(cyc == NF + 1, "R8 full ring latency", cyc, NF + 1);

    // victims take their own mark: 3..7 then wrap to 0,1 (R9)
    for (int k = 0; k < 7; k++) begin
      run_req(0, 0, idx, cyc);
      check(idx == (3 + k) % NF, "R9 ascending order with wrap", idx, (3 + k) % NF);
    end
    run_req(0, 0, idx, cyc);
    check(idx == 2, "R5 victims marked so ring full", idx, 2);
    check(cyc == NF + 1, "R5 marked victims force revolution", cyc, NF + 1);

    // marks on 3 and 4 (R6); reference 3 exactly as search clears it (R7)
    touch(3);
    touch(4);
    run_req(1, 3, idx, cyc);
    check(idx == 5, "R3 skips marked frames", idx, 5);
    check(cyc == 3, "R3 one frame per cycle", cyc, 3);
    for (int k = 0; k < 4; k++) begin
      run_req(0, 0, idx, cyc);
      check(idx == (6 + k) % NF, "R6 unmarked frames taken", idx, (6 + k) % NF);
    end
    run_req(0, 0, idx, cyc);
    check(idx == 4, "R7 reference kept frame 3 marked", idx, 4);
    check(cyc == 3, "R7 search length", cyc, 3);

    // random traffic, compared to model each clock
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      req_valid  = ($urandom_range(0, 3) == 0);
      ref_strobe = ($urandom_range(0, 2) == 0);
      ref_frame  = 3'($urandom_range(0, NF - 1));
    end
    @(negedge clk);
    req_valid  = 1'b0;
    ref_strobe = 1'b0;
    repeat (40) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule